// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block keeps the transmit error counter (TEC) and receive error counter (REC) of a CAN node and derives the node's fault-confinement state from them. The protocol engine reports error events as increment and decrement strobes. Software programs a warning limit and can preset both counters while the node is held in reset mode. The block publishes three status bits: error status, error passive and bus status. It records two interrupt causes, one for warning and bus changes and one for error-passive changes. Each cause can be enabled or disabled, and each flag is held until software acknowledges it.

When the TEC would reach 256, the node goes bus-off. The TEC is parked at 127, the REC is cleared and reset mode is forced on. Recovery does not start until software clears reset mode. After that, each report of 11 consecutive recessive bits counts down the TEC. The 128th report ends recovery and returns the node to error active with a TEC of zero. The status bits are frozen while reset mode is on, so counter presets take effect only once the node runs again.

Top module: `can_fault_confine`

## Requirements
- R1: After reset the warning limit is 96, TEC and REC are 0, reset mode is 1, and all status bits, interrupt flags and `irq_o` are 0.
- R2: A configuration write loads `wr_data_i` into the target selected by `wr_sel_i` (0 = warning limit, 1 = TEC, 2 = REC, 3 = none) only while reset mode is 1. A write made outside reset mode has no effect.
- R3: While neither reset mode nor bus-off is active, `tec_inc_i` adds `tec_step_i` to the TEC, and otherwise `tec_dec_i` subtracts 1, stopping at 0. An increment wins over a decrement in the same cycle. In reset mode the TEC only changes through a write.
- R4: `rec_inc_i` adds `rec_step_i` to the REC, saturating at 255, and otherwise `rec_dec_i` subtracts 1, stopping at 0. This applies in reset mode and during bus-off as well. While `listen_only_i` is 1, the REC does not move except by a write or on bus-off entry.
- R5: Error status is 1 when the TEC or the REC is at or above the warning limit. It is re-evaluated one cycle after the counters change, and only while reset mode is 0.
- R6: Error passive is 1 when the TEC or the REC is at or above 128. It follows the same timing and the same reset-mode freeze as R5.
- R7: A TEC increment whose sum reaches 256 sets bus status, loads 127 into the TEC, clears the REC and sets reset mode, all at the same clock edge.
- R8: Recovery advances only while bus status is 1 and reset mode is 0. Each `idle11_i` strobe lowers the TEC by 1. The 128th strobe clears bus status and sets the TEC to 0. Strobes received outside recovery are ignored.
- R9: Flag bit 0 (warning) is set one cycle after error status or bus status changes, provided `irq_en_i[0]` is 1.
- R10: Flag bit 1 (passive) is set one cycle after error passive changes, provided `irq_en_i[1]` is 1.
- R11: A flag stays set until a cycle with `irq_ack_i` is 1. A new event in the acknowledge cycle keeps its flag set. `irq_o` is the OR of both flags.
- R12: `mode_wr_i` loads `mode_reset_i` into reset mode. Bus-off entry in the same cycle overrides the write and forces reset mode to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tec_inc_i | input | 1 | TEC increment strobe |
| tec_step_i | input | 4 | Amount added to the TEC |
| tec_dec_i | input | 1 | TEC decrement strobe |
| rec_inc_i | input | 1 | REC increment strobe |
| rec_step_i | input | 4 | Amount added to the REC |
| rec_dec_i | input | 1 | REC decrement strobe |
| idle11_i | input | 1 | Strobe for 11 consecutive recessive bits |
| listen_only_i | input | 1 | Listen-only mode; freezes the REC |
| mode_wr_i | input | 1 | Reset-mode bit write strobe |
| mode_reset_i | input | 1 | Value written to the reset-mode bit |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 2 | Write target (0 limit, 1 TEC, 2 REC, 3 none) |
| wr_data_i | input | 8 | Write data |
| irq_en_i | input | 2 | Interrupt enables (bit 0 warning, bit 1 passive) |
| irq_ack_i | input | 1 | Interrupt read/acknowledge strobe |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| ewl_o | output | 8 | Warning limit |
| reset_mode_o | output | 1 | Reset-mode bit |
| bus_status_o | output | 1 | Bus-off indication |
| err_status_o | output | 1 | Warning-level indication |
| err_passive_o | output | 1 | Error-passive indication |
| irq_flags_o | output | 2 | Held interrupt flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Results arrive at three depths. The counters, reset mode and bus status change at the first clock edge after a strobe. Error status and error passive change at the second edge. The flag for a counter-driven status change is set at the third edge, while the flag for a bus-status change is set at the second. The bench keeps a cycle model that advances once per clock from the inputs it applied before that edge. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. The directed checks are placed with the same edge counts.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    SEL_EWL  = 2'd0,
    SEL_TEC  = 2'd1,
    SEL_REC  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  localparam int IRQ_WARN = 0;
  localparam int IRQ_PASS = 1;
  localparam int IRQ_N    = 2;
endpackage

// File: rtl/can_fc_counters.sv
module can_fc_counters
  import can_fc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int STEP_W      = 4,
  parameter int EWL_RST     = 96,
  parameter int TEC_PARK    = 127,
  parameter int RECOV_COUNT = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tec_inc_i,
  input  logic [STEP_W-1:0] tec_step_i,
  input  logic             tec_dec_i,
  input  logic             rec_inc_i,
  input  logic [STEP_W-1:0] rec_step_i,
  input  logic             rec_dec_i,
  input  logic             idle11_i,
  input  logic             listen_only_i,
  input  logic             mode_wr_i,
  input  logic             mode_reset_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic [CNT_W-1:0] ewl_o,
  output logic             reset_mode_o,
  output logic             bus_off_o
);
  localparam int RC_W = (RECOV_COUNT > 1) ? $clog2(RECOV_COUNT) : 1;

  logic [CNT_W-1:0] tec_q, rec_q, ewl_q;
  logic             rm_q, bo_q;
  logic [RC_W-1:0]  rcnt_q;
  logic [CNT_W:0]   tec_sum, rec_sum;
  logic             wr_ok, wr_tec, wr_rec, wr_ewl;
  logic             busoff_hit, recov_tick, recov_done;

  assign tec_sum    = {1'b0, tec_q} + (CNT_W+1)'(tec_step_i);
  assign rec_sum    = {1'b0, rec_q} + (CNT_W+1)'(rec_step_i);
  assign wr_ok      = wr_en_i && rm_q;
  assign wr_tec     = wr_ok && (wr_sel_i == SEL_TEC);
  assign wr_rec     = wr_ok && (wr_sel_i == SEL_REC);
  assign wr_ewl     = wr_ok && (wr_sel_i == SEL_EWL);
  assign busoff_hit = tec_inc_i && !rm_q && !bo_q && tec_sum[CNT_W];
  assign recov_tick = bo_q && !rm_q && idle11_i;
  assign recov_done = recov_tick && (rcnt_q == RC_W'(RECOV_COUNT-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tec_q  <= '0;
      rec_q  <= '0;
      ewl_q  <= CNT_W'(EWL_RST);
      rm_q   <= 1'b1;
      bo_q   <= 1'b0;
      rcnt_q <= '0;
    end else begin
      // TEC
      if (wr_tec)                 tec_q <= wr_data_i;
      else if (busoff_hit)        tec_q <= CNT_W'(TEC_PARK);
      else if (recov_done)        tec_q <= '0;
      else if (recov_tick)        tec_q <= (tec_q != '0) ? tec_q - 1'b1 : tec_q;
      else if (!rm_q && !bo_q) begin
        if (tec_inc_i)                   tec_q <= tec_sum[CNT_W-1:0];
        else if (tec_dec_i && tec_q != '0) tec_q <= tec_q - 1'b1;
      end
      // REC keeps counting in reset mode and bus-off unless listen-only
      if (wr_rec)                 rec_q <= wr_data_i;
      else if (busoff_hit)        rec_q <= '0;
      else if (!listen_only_i) begin
        if (rec_inc_i)                   rec_q <= rec_sum[CNT_W] ? '1 : rec_sum[CNT_W-1:0];
        else if (rec_dec_i && rec_q != '0) rec_q <= rec_q - 1'b1;
      end
      if (wr_ewl) ewl_q <= wr_data_i;
      if (busoff_hit)      rm_q <= 1'b1;
      else if (mode_wr_i)  rm_q <= mode_reset_i;
      if (busoff_hit)      bo_q <= 1'b1;
      else if (recov_done) bo_q <= 1'b0;
      if (busoff_hit || recov_done) rcnt_q <= '0;
      else if (recov_tick)          rcnt_q <= rcnt_q + 1'b1;
    end
  end

  assign tec_o        = tec_q;
  assign rec_o        = rec_q;
  assign ewl_o        = ewl_q;
  assign reset_mode_o = rm_q;
  assign bus_off_o    = bo_q;

  assert_tec_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rm_q && !wr_tec) |=> $stable(tec_q));
  assert_rec_listen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (listen_only_i && !busoff_hit && !wr_rec) |=> $stable(rec_q));
  assert_busoff_park_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bo_q) |-> (tec_q == CNT_W'(TEC_PARK) && rec_q == '0 && rm_q));
  assert_recov_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bo_q) |-> (tec_q == '0 && !rm_q));
  assert_busoff_rm_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busoff_hit |=> rm_q);
endmodule

// File: rtl/can_fc_status.sv
module can_fc_status #(
  parameter int CNT_W       = 8,
  parameter int PASSIVE_LVL = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  input  logic [CNT_W-1:0] ewl_i,
  input  logic             reset_mode_i,
  input  logic             bus_off_i,
  output logic             err_status_o,
  output logic             err_passive_o,
  output logic             warn_chg_o,
  output logic             pass_chg_o
);
  logic err_q, pas_q, err_prev_q, pas_prev_q, bus_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q      <= 1'b0;
      pas_q      <= 1'b0;
      err_prev_q <= 1'b0;
      pas_prev_q <= 1'b0;
      bus_prev_q <= 1'b0;
    end else begin
      // Frozen in reset mode so presets act only once the node runs
      if (!reset_mode_i) begin
        err_q <= (tec_i >= ewl_i) || (rec_i >= ewl_i);
        pas_q <= (tec_i >= CNT_W'(PASSIVE_LVL)) || (rec_i >= CNT_W'(PASSIVE_LVL));
      end
      err_prev_q <= err_q;
      pas_prev_q <= pas_q;
      bus_prev_q <= bus_off_i;
    end
  end

  assign err_status_o  = err_q;
  assign err_passive_o = pas_q;
  assign warn_chg_o    = (err_q ^ err_prev_q) | (bus_off_i ^ bus_prev_q);
  assign pass_chg_o    = pas_q ^ pas_prev_q;

  assert_status_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_mode_i |=> ($stable(err_q) && $stable(pas_q)));
  assert_passive_warn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reset_mode_i && ewl_i <= CNT_W'(PASSIVE_LVL) && (tec_i >= CNT_W'(PASSIVE_LVL))) |=> (pas_q && err_q));
endmodule

// File: rtl/can_fc_irq.sv
module can_fc_irq
  import can_fc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_N-1:0] event_i,
  input  logic [IRQ_N-1:0] en_i,
  input  logic             ack_i,
  output logic [IRQ_N-1:0] flags_o
);
  logic [IRQ_N-1:0] flag_q;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= (flag_q[g] && !ack_i) || (event_i[g] && en_i[g]);
    end

    assert_irq_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !ack_i) |=> flag_q[g]);
    assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[g] |=> !$rose(flag_q[g]));
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import can_fc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int STEP_W      = 4,
  parameter int EWL_RST     = 96,
  parameter int PASSIVE_LVL = 128,
  parameter int TEC_PARK    = 127,
  parameter int RECOV_COUNT = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tec_inc_i,
  input  logic [STEP_W-1:0] tec_step_i,
  input  logic              tec_dec_i,
  input  logic              rec_inc_i,
  input  logic [STEP_W-1:0] rec_step_i,
  input  logic              rec_dec_i,
  input  logic              idle11_i,
  input  logic              listen_only_i,
  input  logic              mode_wr_i,
  input  logic              mode_reset_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [IRQ_N-1:0]  irq_en_i,
  input  logic              irq_ack_i,
  output logic [CNT_W-1:0]  tec_o,
  output logic [CNT_W-1:0]  rec_o,
  output logic [CNT_W-1:0]  ewl_o,
  output logic              reset_mode_o,
  output logic              bus_status_o,
  output logic              err_status_o,
  output logic              err_passive_o,
  output logic [IRQ_N-1:0]  irq_flags_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] tec, rec, ewl;
  logic             rm, bo, warn_chg, pass_chg;
  logic [IRQ_N-1:0] events;

  can_fc_counters #(
    .CNT_W(CNT_W), .STEP_W(STEP_W), .EWL_RST(EWL_RST),
    .TEC_PARK(TEC_PARK), .RECOV_COUNT(RECOV_COUNT)
  ) i_counters (
    .clk_i, .rst_ni, .tec_inc_i, .tec_step_i, .tec_dec_i,
    .rec_inc_i, .rec_step_i, .rec_dec_i, .idle11_i, .listen_only_i,
    .mode_wr_i, .mode_reset_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .tec_o(tec), .rec_o(rec), .ewl_o(ewl), .reset_mode_o(rm), .bus_off_o(bo)
  );

  can_fc_status #(.CNT_W(CNT_W), .PASSIVE_LVL(PASSIVE_LVL)) i_status (
    .clk_i, .rst_ni, .tec_i(tec), .rec_i(rec), .ewl_i(ewl),
    .reset_mode_i(rm), .bus_off_i(bo),
    .err_status_o, .err_passive_o, .warn_chg_o(warn_chg), .pass_chg_o(pass_chg)
  );

  always_comb begin
    events           = '0;
    events[IRQ_WARN] = warn_chg;
    events[IRQ_PASS] = pass_chg;
  end

  can_fc_irq i_irq (
    .clk_i, .rst_ni, .event_i(events), .en_i(irq_en_i), .ack_i(irq_ack_i),
    .flags_o(irq_flags_o)
  );

  assign tec_o        = tec;
  assign rec_o        = rec;
  assign ewl_o        = ewl;
  assign reset_mode_o = rm;
  assign bus_status_o = bo;
  assign irq_o        = |irq_flags_o;

  assert_irq_or_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (irq_flags_o != '0));
endmodule

// File: tb/test_can_fault_confine.sv
module test_can_fault_confine;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tec_inc = 0, tec_dec = 0, rec_inc = 0, rec_dec = 0, idle11 = 0;
  logic [3:0] tec_step = 0, rec_step = 0;
  logic listen = 0, mode_wr = 0, mode_rst = 0, wr_en = 0, ack = 0;
  logic [1:0] wr_sel = 0, irq_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] tec_o, rec_o, ewl_o;
  logic rm_o, bus_o, err_o, pas_o, irq_o;
  logic [1:0] flags_o;

  int n_tests = 0, n_fail = 0;

  // reference state
  int m_tec = 0, m_rec = 0, m_ewl = 96, m_rcnt = 0;
  bit m_rm = 1, m_bo = 0, m_err = 0, m_pas = 0, m_errp = 0, m_pasp = 0, m_bop = 0;
  bit [1:0] m_fl = 0;

  always #5 clk = ~clk;

  can_fault_confine i_can_fault_confine (
    .clk_i(clk), .rst_ni(rst_ni), .tec_inc_i(tec_inc), .tec_step_i(tec_step),
    .tec_dec_i(tec_dec), .rec_inc_i(rec_inc), .rec_step_i(rec_step), .rec_dec_i(rec_dec),
    .idle11_i(idle11), .listen_only_i(listen), .mode_wr_i(mode_wr), .mode_reset_i(mode_rst),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .irq_en_i(irq_en),
    .irq_ack_i(ack), .tec_o(tec_o), .rec_o(rec_o), .ewl_o(ewl_o), .reset_mode_o(rm_o),
    .bus_status_o(bus_o), .err_status_o(err_o), .err_passive_o(pas_o),
    .irq_flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int ts, n_tec, n_rec, n_ewl, n_rcnt;
    bit wr_ok, hit, tick, done, n_rm, n_bo, n_err, n_pas, wchg, pchg;
    bit [1:0] n_fl;
    wr_ok = m_rm && wr_en;
    ts    = m_tec + int'(tec_step);
    hit   = tec_inc && !m_rm && !m_bo && ts >= 256;
    tick  = m_bo && !m_rm && idle11;
    done  = tick && m_rcnt == 127;
    n_tec = m_tec;
    if (wr_ok && wr_sel == 1) n_tec = wr_data;
    else if (hit) n_tec = 127;
    else if (done) n_tec = 0;
    else if (tick) n_tec = (m_tec > 0) ? m_tec - 1 : 0;
    else if (!m_rm && !m_bo) begin
      if (tec_inc) n_tec = ts;
      else if (tec_dec && m_tec > 0) n_tec = m_tec - 1;
    end
    n_rec = m_rec;
    if (wr_ok && wr_sel == 2) n_rec = wr_data;
    else if (hit) n_rec = 0;
    else if (!listen) begin
      if (rec_inc) n_rec = (m_rec + int'(rec_step) > 255) ? 255 : m_rec + int'(rec_step);
      else if (rec_dec && m_rec > 0) n_rec = m_rec - 1;
    end
    n_ewl = (wr_ok && wr_sel == 0) ? int'(wr_data) : m_ewl;
    n_rm  = hit ? 1'b1 : (mode_wr ? mode_rst : m_rm);
    n_bo  = hit ? 1'b1 : (done ? 1'b0 : m_bo);
    n_rcnt = (hit || done) ? 0 : (tick ? m_rcnt + 1 : m_rcnt);
    n_err = m_err; n_pas = m_pas;
    if (!m_rm) begin
      n_err = (m_tec >= m_ewl) || (m_rec >= m_ewl);
      n_pas = (m_tec >= 128) || (m_rec >= 128);
    end
    wchg = (m_err != m_errp) || (m_bo != m_bop);
    pchg = (m_pas != m_pasp);
    n_fl[0] = (m_fl[0] && !ack) || (wchg && irq_en[0]);
    n_fl[1] = (m_fl[1] && !ack) || (pchg && irq_en[1]);
    m_errp = m_err; m_pasp = m_pas; m_bop = m_bo;
    m_tec = n_tec; m_rec = n_rec; m_ewl = n_ewl; m_rm = n_rm; m_bo = n_bo;
    m_rcnt = n_rcnt; m_err = n_err; m_pas = n_pas; m_fl = n_fl;
  endtask

  task automatic compare_all();
    chk("R3 tec", tec_o, m_tec);
    chk("R4 rec", rec_o, m_rec);
    chk("R2 ewl", ewl_o, m_ewl);
    chk("R12 reset_mode", rm_o, m_rm);
    chk("R7 bus_status", bus_o, m_bo);
    chk("R5 err_status", err_o, m_err);
    chk("R6 err_passive", pas_o, m_pas);
    chk("R9 warn flag", flags_o[0], m_fl[0]);
    chk("R10 passive flag", flags_o[1], m_fl[1]);
    chk("R11 irq", irq_o, m_fl != 0);
  endtask

  task automatic quiet();
    tec_inc = 0; tec_dec = 0; rec_inc = 0; rec_dec = 0; idle11 = 0;
    mode_wr = 0; wr_en = 0; ack = 0;
  endtask

  task automatic cycle();
    model_step();
    @(negedge clk);
    compare_all();
    quiet();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tec", tec_o, 0); chk("R1 rec", rec_o, 0); chk("R1 ewl", ewl_o, 96);
    chk("R1 reset_mode", rm_o, 1); chk("R1 status", {bus_o, err_o, pas_o}, 0);
    chk("R1 irq", {flags_o, irq_o}, 0);
    rst_ni = 1;
    irq_en = 2'b11;
    // preset TEC in reset mode (R2)
    wr_en = 1; wr_sel = 1; wr_data = 130; cycle();
    chk("R2 preset tec", tec_o, 130);
    cycle();
    chk("R5 frozen in reset mode", err_o, 0);
    mode_wr = 1; mode_rst = 0; cycle();
    cycle();
    chk("R5 err after run", err_o, 1);
    chk("R6 passive after run", pas_o, 1);
    cycle();
    chk("R9 warn flag", flags_o[0], 1);
    chk("R10 passive flag", flags_o[1], 1);
    // write outside reset mode ignored (R2)
    wr_en = 1; wr_sel = 1; wr_data = 5; cycle();
    chk("R2 ignored write", tec_o, 130);
    ack = 1; cycle();
    chk("R11 ack clears", irq_o, 0);
    // drive to bus-off (R7)
    for (int i = 0; i < 40 && !bus_o; i++) begin
      rec_inc = 1; rec_step = 3; tec_inc = 1; tec_step = 8; cycle();
    end
    chk("R7 bus_off tec", tec_o, 127);
    chk("R7 bus_off rec", rec_o, 0);
    chk("R7 bus_off reset_mode", rm_o, 1);
    // REC in bus-off, then listen-only (R4)
    rec_inc = 1; rec_step = 1; cycle();
    chk("R4 rec in bus-off", rec_o, 1);
    listen = 1; rec_inc = 1; rec_step = 5; cycle();
    chk("R4 rec listen frozen", rec_o, 1);
    listen = 0;
    // recovery blocked in reset mode (R8)
    for (int i = 0; i < 3; i++) begin idle11 = 1; cycle(); end
    chk("R8 no recovery in reset mode", tec_o, 127);
    mode_wr = 1; mode_rst = 0; cycle();
    for (int i = 0; i < 127; i++) begin idle11 = 1; cycle(); end
    chk("R8 bus still off after 127", bus_o, 1);
    chk("R8 tec at 0", tec_o, 0);
    idle11 = 1; cycle();
    chk("R8 recovered", bus_o, 0);
    // gating (R9, R10) and decrement (R3)
    irq_en = 0; ack = 1; cycle();
    cycle();
    for (int i = 0; i < 17; i++) begin tec_inc = 1; tec_step = 8; cycle(); end
    tec_dec = 1; tec_inc = 0; cycle();
    chk("R3 dec", tec_o, 135);
    repeat (3) cycle();
    chk("R9 R10 gated", flags_o, 0);
    chk("R6 passive", pas_o, 1);
    mode_wr = 1; mode_rst = 1; cycle();
    chk("R12 reset mode set", rm_o, 1);
    // constrained random
    irq_en = 2'b11;
    for (int i = 0; i < 4000; i++) begin
      tec_inc  = ($urandom % 4) == 0;
      tec_step = ($urandom % 2) ? 4'd8 : 4'd1;
      tec_dec  = ($urandom % 3) == 0;
      rec_inc  = ($urandom % 4) == 0;
      rec_step = ($urandom % 2) ? 4'd8 : 4'd1;
      rec_dec  = ($urandom % 3) == 0;
      idle11   = ($urandom % 2) == 0;
      mode_wr  = ($urandom % 40) == 0;
      mode_rst = ($urandom % 4) == 0;
      wr_en    = ($urandom % 8) == 0;
      wr_sel   = 2'($urandom);
      wr_data  = 8'($urandom);
      ack      = ($urandom % 10) == 0;
      if (($urandom % 100) == 0) listen = ~listen;
      if (($urandom % 200) == 0) irq_en = 2'($urandom);
      cycle();
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule